// File: doc/BRIEF.md
# Handshaked SPI Transaction Slave

This block is the slave end of a serial link that adds three active-low handshake lines to a plain SPI bus. The master pulls the request line low before every transfer. The slave answers on the ready line, and only after that answer will it shift data. When the local host has something to send, the slave pulls its own service-request line low so the master starts a transaction. Every handshake line idles high.

A transaction holds one or two transfers. The first transfer always has the same byte count, set by a parameter. Byte 0 of the first transfer declares a second-transfer length in each direction. The slave takes the larger of the two declared lengths and limits it to the largest allowed transfer. If that length is zero, the transaction ends after the first transfer. Data moves in both directions in the same transfers.

The local host writes uplink bytes into a byte-addressed transmit buffer. It receives downlink bytes one at a time, each with its buffer index. A one-cycle done pulse closes each transaction. An abort pulse drops the transaction at any point.

Top module: `hs_spi_slave`

## Requirements
- R1: After reset, `srdy_n` and `hreq_n` are high, and `rx_valid` and `txn_done` are low.
- R2: When idle with `sreq_n` high and `up_pend` high, the block drives `hreq_n` low within 4 cycles and keeps it low until `sreq_n` is seen low.
- R3: Within 4 cycles of `sreq_n` going low, `srdy_n` is low and `hreq_n` is high.
- R4: Within 4 cycles of the master releasing `sreq_n` high, `srdy_n` is high again, and data may then be clocked.
- R5: The first transfer holds exactly `FIX_BYTES` bytes. Each downlink byte appears once on `rx_data` with `rx_valid`, and `rx_idx` gives its buffer index (0 upward).
- R6: SPI mode is CPHA=1, MSB first. With CPOL=0, `spi_miso` changes after the rising SCLK edge and is sampled by the master on the falling edge. Uplink byte k is the transmit-buffer byte at address k.
- R7: The second-transfer length is max(downlink byte 0, uplink buffer byte 0), limited to `MAX_BYTES`. If it is zero, no second handshake is served and all lines stay high.
- R8: A second transfer needs a new handshake. Its bytes use buffer indices from `FIX_BYTES` upward, in both directions.
- R9: `txn_done` pulses for exactly one cycle when the last byte of a transaction has been received.
- R10: An `abort` pulse sets both handshake lines high and returns the block to idle. SCLK edges that follow produce no `rx_valid`.
- R11: SCLK edges are ignored unless the block is in the transfer state, that is, after a completed handshake.
- R12: SCLK edges while `spi_ss_n` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort | input | 1 | One-cycle pulse that drops the current transaction |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| sreq_n | input | 1 | Active-low transfer request from the master |
| srdy_n | output | 1 | Active-low slave-ready answer |
| hreq_n | output | 1 | Active-low service request to the master |
| up_pend | input | 1 | Local host has an uplink message waiting |
| tx_we | input | 1 | Transmit-buffer write enable |
| tx_addr | input | AW | Transmit-buffer byte address |
| tx_data | input | 8 | Transmit-buffer write data |
| rx_valid | output | 1 | A downlink byte is presented |
| rx_data | output | 8 | Downlink byte |
| rx_idx | output | AW | Buffer index of the downlink byte |
| txn_done | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
The assertions assume the master follows the handshake. It starts SCLK only after `srdy_n` has fallen and risen again. It holds each SCLK level long enough for the three-stage synchronizer to see it, and it does not change MOSI near a sampling edge. The bench master holds each SCLK phase for eight system clocks and changes MOSI only on the leading edge. It always waits for the ready answer before clocking, except in the directed cases that check clocks are ignored outside a transfer. The host writes the transmit buffer only between transactions.

// File: rtl/hs_spi_slave.sv
module hs_spi_slave #(
  parameter int FIX_BYTES = 4,
  parameter int MAX_BYTES = 31,
  parameter bit CPOL      = 1'b0,
  parameter int AW        = $clog2(FIX_BYTES + MAX_BYTES)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          spi_sclk,
  input  logic          spi_ss_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic          sreq_n,
  output logic          srdy_n,
  output logic          hreq_n,
  input  logic          up_pend,
  input  logic          tx_we,
  input  logic [AW-1:0] tx_addr,
  input  logic [7:0]    tx_data,
  output logic          rx_valid,
  output logic [7:0]    rx_data,
  output logic [AW-1:0] rx_idx,
  output logic          txn_done
);
  localparam int DEPTH = FIX_BYTES + MAX_BYTES;
  localparam int CW    = $clog2(((FIX_BYTES > MAX_BYTES) ? FIX_BYTES : MAX_BYTES) + 2);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ARM, S_XFER, S_WAIT2} st_t;

  logic [7:0] tbuf [1<<AW];

  always_ff @(posedge clk)
    if (tx_we) tbuf[tx_addr] <= tx_data;

  logic [2:0] sclk_q;
  logic [1:0] sreq_q, ss_q, mosi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= {3{CPOL}};
      sreq_q <= 2'b11;
      ss_q   <= 2'b11;
      mosi_q <= 2'b00;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      sreq_q <= {sreq_q[0], sreq_n};
      ss_q   <= {ss_q[0], spi_ss_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire sreq_s = sreq_q[1];
  wire ss_s   = ss_q[1];
  wire mosi_s = mosi_q[1];
  wire lead   = (sclk_q[2] == CPOL) && (sclk_q[1] != CPOL);
  wire trail  = (sclk_q[2] != CPOL) && (sclk_q[1] == CPOL);

  st_t           state;
  logic          phase;
  logic [2:0]    bitcnt;
  logic [CW-1:0] bytecnt, len2;
  logic [7:0]    tx_sh, rx_sh, rx_len0;
  logic          miso_r;

  wire [CW-1:0] cur_len = phase ? len2 : CW'(FIX_BYTES);
  wire [AW-1:0] base    = phase ? AW'(FIX_BYTES) : '0;
  wire [CW-1:0] nxt_cnt = bytecnt + 1'b1;
  wire          last    = (nxt_cnt == cur_len);
  wire [7:0]    rx_next = {rx_sh[6:0], mosi_s};
  wire [AW-1:0] fetch_i = base + AW'(nxt_cnt);
  wire [7:0]    fetch_b = (nxt_cnt < cur_len) ? tbuf[fetch_i] : 8'h00;
  wire [7:0]    r0      = (bytecnt == '0) ? rx_next : rx_len0;
  wire [7:0]    t0      = tbuf[0];
  wire [7:0]    big     = (r0 > t0) ? r0 : t0;
  wire [CW-1:0] l2      = (big > 8'(MAX_BYTES)) ? CW'(MAX_BYTES) : CW'(big);
  wire          shift_on = (state == S_XFER) && !ss_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      phase    <= 1'b0;
      bitcnt   <= '0;
      bytecnt  <= '0;
      len2     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      rx_len0  <= '0;
      miso_r   <= 1'b0;
      srdy_n   <= 1'b1;
      hreq_n   <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_idx   <= '0;
      txn_done <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      txn_done <= 1'b0;
      if (abort) begin
        state   <= S_IDLE;
        phase   <= 1'b0;
        bitcnt  <= '0;
        bytecnt <= '0;
        tx_sh   <= '0;
        rx_sh   <= '0;
        miso_r  <= 1'b0;
        srdy_n  <= 1'b1;
        hreq_n  <= 1'b1;
      end else begin
        unique case (state)
          S_IDLE, S_REQ: begin
            if (!sreq_s) begin
              state   <= S_ARM;
              hreq_n  <= 1'b1;
              srdy_n  <= 1'b0;
              phase   <= 1'b0;
              tx_sh   <= tbuf[0];
              bitcnt  <= '0;
              bytecnt <= '0;
              miso_r  <= 1'b0;
            end else if (state == S_IDLE && up_pend) begin
              state  <= S_REQ;
              hreq_n <= 1'b0;
            end
          end
          S_WAIT2: begin
            if (!sreq_s) begin
              state   <= S_ARM;
              srdy_n  <= 1'b0;
              tx_sh   <= tbuf[AW'(FIX_BYTES)];
              bitcnt  <= '0;
              bytecnt <= '0;
              miso_r  <= 1'b0;
            end
          end
          S_ARM: begin
            if (sreq_s) begin
              state  <= S_XFER;
              srdy_n <= 1'b1;
            end
          end
          S_XFER: begin
            if (shift_on && lead) begin
              miso_r <= tx_sh[7];
              tx_sh  <= {tx_sh[6:0], 1'b0};
            end else if (shift_on && trail) begin
              rx_sh  <= rx_next;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 3'd7) begin
                rx_valid <= 1'b1;
                rx_data  <= rx_next;
                rx_idx   <= base + AW'(bytecnt);
                if (!phase && bytecnt == '0) rx_len0 <= rx_next;
                bytecnt <= nxt_cnt;
                tx_sh   <= fetch_b;
                if (last) begin
                  if (!phase && l2 != '0) begin
                    state <= S_WAIT2;
                    phase <= 1'b1;
                    len2  <= l2;
                  end else begin
                    state    <= S_IDLE;
                    phase    <= 1'b0;
                    txn_done <= 1'b1;
                  end
                end
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end

  assign spi_miso = miso_r;

  AST_HREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hreq_n && sreq_s && !abort) |=> !hreq_n); // R2
  AST_READY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srdy_n) |-> $past(!sreq_s)); // R3
  AST_RX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (int'(rx_idx) < DEPTH)); // R5
  AST_SECOND_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT2) |-> (len2 != '0 && int'(len2) <= MAX_BYTES)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |=> !txn_done); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (srdy_n && hreq_n && !rx_valid)); // R10
  AST_RX_ONLY_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(state == S_XFER)); // R11
endmodule

// File: tb/hs_spi_slave_bench.sv
`timescale 1ns/1ps
module hs_spi_slave_bench;
  localparam int FIX = 4;
  localparam int MAXB = 31;
  localparam int AW = $clog2(FIX + MAXB);
  localparam int DEPTH = FIX + MAXB;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, abort = 1'b0;
  logic spi_sclk = 1'b0, spi_ss_n = 1'b1, spi_mosi = 1'b0, spi_miso;
  logic sreq_n = 1'b1, srdy_n, hreq_n, up_pend = 1'b0;
  logic tx_we = 1'b0;
  logic [AW-1:0] tx_addr = '0;
  logic [7:0] tx_data = '0;
  logic rx_valid, txn_done;
  logic [7:0] rx_data;
  logic [AW-1:0] rx_idx;

  hs_spi_slave #(.FIX_BYTES(FIX), .MAX_BYTES(MAXB), .CPOL(1'b0)) u_hs_spi_slave (
    .clk(clk), .rst_n(rst_n), .abort(abort),
    .spi_sclk(spi_sclk), .spi_ss_n(spi_ss_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .sreq_n(sreq_n), .srdy_n(srdy_n), .hreq_n(hreq_n), .up_pend(up_pend),
    .tx_we(tx_we), .tx_addr(tx_addr), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_idx(rx_idx), .txn_done(txn_done));

  // vector: [24] slave-initiated, [23:16] downlink byte0, [15:8] uplink byte0, [7:0] expected second length
  localparam logic [24:0] VEC [4] = '{
    {1'b0, 8'd2,  8'd5, 8'd5},
    {1'b1, 8'd7,  8'd3, 8'd7},
    {1'b0, 8'd0,  8'd0, 8'd0},
    {1'b1, 8'd40, 8'd1, 8'd31}
  };

  int checks = 0, errors = 0;
  int rx_cnt = 0, done_cnt = 0;
  logic [7:0] cap [64];
  logic [7:0] mst_tx [64];
  logic [7:0] mst_rx [64];
  logic [7:0] ubuf [64];

  always @(negedge clk) begin
    if (rx_valid) begin
      cap[rx_idx] = rx_data;
      rx_cnt = rx_cnt + 1;
    end
    if (txn_done) done_cnt = done_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      spi_sclk = 1'b1;
      spi_mosi = mo[i];
      repeat (8) @(negedge clk);
      spi_sclk = 1'b0;
      mi[i] = spi_miso;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic write_buf(input int a, input logic [7:0] d);
    @(negedge clk);
    tx_we = 1'b1; tx_addr = AW'(a); tx_data = d;
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  task automatic hs_xfer(input int start, input int n, input bit ghost);
    logic [7:0] dummy;
    int c0;
    @(negedge clk);
    sreq_n = 1'b0;
    repeat (4) @(negedge clk);
    check(srdy_n == 1'b0, "R3 srdy low", srdy_n, 0);
    check(hreq_n == 1'b1, "R3 hreq high", hreq_n, 1);
    up_pend = 1'b0;
    sreq_n = 1'b1;
    repeat (4) @(negedge clk);
    check(srdy_n == 1'b1, "R4 srdy released", srdy_n, 1);
    if (ghost) begin
      c0 = rx_cnt;
      spi_byte(8'h5A, dummy);
      repeat (4) @(negedge clk);
      check(rx_cnt == c0, "R12 clocks with select high", rx_cnt - c0, 0);
    end
    spi_ss_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < n; k++) spi_byte(mst_tx[start + k], mst_rx[start + k]);
    repeat (2) @(negedge clk);
    spi_ss_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] dummy;
    int c0, d0, bad_rx, bad_tx, tot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(srdy_n == 1'b1, "R1 srdy_n", srdy_n, 1);
    check(hreq_n == 1'b1, "R1 hreq_n", hreq_n, 1);
    check(rx_valid == 1'b0 && txn_done == 1'b0, "R1 outputs low", rx_valid, 0);

    // R11: clocks while idle
    c0 = rx_cnt;
    spi_ss_n = 1'b0;
    spi_byte(8'hC3, dummy);
    spi_ss_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rx_cnt == c0, "R11 idle clocks ignored", rx_cnt - c0, 0);

    // R10: abort in the middle of a transfer
    for (int a = 0; a < DEPTH; a++) write_buf(a, 8'h11);
    d0 = done_cnt;
    sreq_n = 1'b0; repeat (4) @(negedge clk);
    sreq_n = 1'b1; repeat (4) @(negedge clk);
    spi_ss_n = 1'b0; repeat (2) @(negedge clk);
    c0 = rx_cnt;
    spi_byte(8'h00, dummy);
    repeat (2) @(negedge clk);
    check(rx_cnt == c0 + 1, "R5 byte before abort", rx_cnt - c0, 1);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    repeat (2) @(negedge clk);
    check(srdy_n == 1'b1 && hreq_n == 1'b1, "R10 lines high after abort", {srdy_n, hreq_n}, 3);
    c0 = rx_cnt;
    spi_byte(8'h00, dummy);
    spi_byte(8'h00, dummy);
    spi_ss_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rx_cnt == c0, "R10 clocks after abort ignored", rx_cnt - c0, 0);
    check(done_cnt == d0, "R10 no done after abort", done_cnt - d0, 0);

    // R10: abort while requesting service
    up_pend = 1'b1; repeat (4) @(negedge clk);
    check(hreq_n == 1'b0, "R2 hreq asserted", hreq_n, 0);
    up_pend = 1'b0; abort = 1'b1; @(negedge clk); abort = 1'b0;
    repeat (2) @(negedge clk);
    check(hreq_n == 1'b1, "R10 hreq released by abort", hreq_n, 1);

    for (int v = 0; v < 4; v++) begin
      for (int a = 0; a < 64; a++) begin
        ubuf[a] = (a == 0) ? VEC[v][15:8] : 8'(8'hA0 + a);
        mst_tx[a] = (a == 0) ? VEC[v][23:16] : 8'(8'h30 + a + v);
        mst_rx[a] = 8'h00;
        cap[a] = 8'hEE;
      end
      for (int a = 0; a < DEPTH; a++) write_buf(a, ubuf[a]);
      c0 = rx_cnt; d0 = done_cnt;
      if (VEC[v][24]) begin
        up_pend = 1'b1;
        repeat (4) @(negedge clk);
        check(hreq_n == 1'b0, "R2 hreq asserted", hreq_n, 0);
        repeat (20) @(negedge clk);
        check(hreq_n == 1'b0 && srdy_n == 1'b1, "R2 hreq held", hreq_n, 0);
      end
      hs_xfer(0, FIX, v == 2);
      check(rx_cnt - c0 == FIX, "R5 first transfer length", rx_cnt - c0, FIX);
      if (VEC[v][7:0] != 0) hs_xfer(FIX, int'(VEC[v][7:0]), 1'b0);
      repeat (10) @(negedge clk);
      tot = FIX + int'(VEC[v][7:0]);
      check(rx_cnt - c0 == tot, "R7 total byte count", rx_cnt - c0, tot);
      check(done_cnt - d0 == 1, "R9 one done pulse", done_cnt - d0, 1);
      check(srdy_n == 1'b1 && hreq_n == 1'b1, "R7 lines idle after transaction", {srdy_n, hreq_n}, 3);
      bad_rx = 0; bad_tx = 0;
      for (int a = 0; a < tot; a++) begin
        if (cap[a] != mst_tx[a]) bad_rx++;
        if (mst_rx[a] != ubuf[a]) bad_tx++;
      end
      check(bad_rx == 0, "R8 downlink bytes by index", bad_rx, 0);
      check(bad_tx == 0, "R6 uplink bytes on miso", bad_tx, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule